// File: doc/BRIEF.md
# Protection Tuple Inserter for Logical Block Writes

This block sits in a storage write path and stamps an 8-byte protection tuple into the metadata area of every logical block in a transfer. Each block enters as one byte-wide valid/ready stream. The data bytes come first, followed by the metadata bytes. The block leaves on a matching output stream. The eight input bytes that occupy the tuple slot are placeholders, and the block replaces them on the fly.

The tuple holds three fields. The first is a 16-bit guard CRC, computed over the block's data and over any metadata bytes that precede the slot. The second is an application tag. The third is a 32-bit reference tag. How the reference tag moves from block to block depends on the protection type. Before a transfer starts, the block runs a consistency check on the supplied reference tag. If the check fails, the command is refused and no bytes are taken.

Splicing is combinational, so a byte flows through in the same cycle it is accepted. The CRC, the tag registers and the block counters are registered.

Top module: `pi_tuple_gen`

## Requirements
- R1: After reset and while idle, `busy`, `outValid`, `inReady` and `done` are all low.
- R2: The guard is CRC-16 with polynomial 0x8BB7, seed 0, no reflection and no final XOR. The seed is reset to zero for every block, so 9 data bytes "123456789" with the tuple first give guard 0xD0DB.
- R3: When `tupleFirst`=0, the tuple occupies metadata offsets mdBytes-8 to mdBytes-1. The guard covers the data bytes and then metadata offsets 0 to mdBytes-9.
- R4: When `tupleFirst`=1, the tuple occupies metadata offsets 0 to 7 and the guard covers the data bytes only. Metadata bytes after the tuple, and all data bytes, leave unchanged.
- R5: Tuple byte k (k=0..7) is: guard[15:8], guard[7:0], app[15:8], app[7:0], ref[31:24], ref[23:16], ref[15:8], ref[7:0].
- R6: For `piType` 1 or 2, block n (counting from 0) carries reference tag `startRef`+n.
- R7: For `piType` 3, every block carries `startRef`.
- R8: A start with `piType`=1, `refCheck`=1 and `startRef`≠`lbaLow` is refused. In that case `done` pulses in the next cycle with `doneStatus`=0x81 and `doneNoRetry`=1, and no byte is accepted. The same mismatch under `piType`=2 is accepted.
- R9: With `piType`=0 no tuple is written and every byte passes unchanged.
- R10: `done` pulses for exactly one cycle, in the cycle after the final byte of the last block is accepted. It then carries `doneStatus`=0x00 and `doneNoRetry`=0.
- R11: While `outReady` is low, `inReady` is low and `outValid` still reflects `inValid`. No byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a transfer (honoured when idle) |
| blkBytes | input | BLK_W | Data bytes per logical block |
| mdBytes | input | MD_W | Metadata bytes per block (at least 8) |
| piType | input | 2 | Protection type 0..3 (0 = none) |
| tupleFirst | input | 1 | 1: tuple at metadata start; 0: at end |
| refCheck | input | 1 | Reference check requested |
| startRef | input | 32 | Reference tag for the first block |
| appTag | input | 16 | Application tag |
| lbaLow | input | 32 | Low 32 bits of the starting block address |
| blkCount | input | CNT_W | Blocks in the transfer (at least 1) |
| inByte | input | 8 | Input stream byte |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted this cycle when valid |
| outByte | output | 8 | Output stream byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream ready |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| doneStatus | output | 8 | Completion code |
| doneNoRetry | output | 1 | Do-not-retry flag for the completion |

## Verification
Every output byte, including the spliced tuple bytes, appears in the same cycle its input byte is presented. The monitor therefore compares `outByte` at the falling edge that precedes the accepting rising edge. `done` follows one rising edge after the final acceptance, so the bench reads it at the first falling edge after that byte and expects it low at the next one. A refused start produces `done` one edge after the edge that samples `start`, and the bench checks it at the falling edge right after.

// File: rtl/pi_gen_pkg.sv
package pi_gen_pkg;

  localparam logic [15:0] GUARD_POLY = 16'h8BB7;
  localparam logic [7:0]  STAT_OK    = 8'h00;
  localparam logic [7:0]  STAT_BADPI = 8'h81;
  localparam int          TUPLE_LEN  = 8;

  typedef struct packed {
    logic crcClr;   // restart guard at zero
    logic crcEn;    // fold inByte into guard
    logic refLoad;  // capture start tag and app tag
    logic refStep;  // advance reference tag
  } dpStrobeT;

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ GUARD_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/pi_gen_ctrl.sv
module pi_gen_ctrl
  import pi_gen_pkg::*;
#(
  parameter int BLK_W = 13,
  parameter int MD_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [BLK_W-1:0] blkBytes,
  input  logic [MD_W-1:0]  mdBytes,
  input  logic [1:0]       piType,
  input  logic             tupleFirst,
  input  logic             refCheck,
  input  logic [31:0]      startRef,
  input  logic [31:0]      lbaLow,
  input  logic [CNT_W-1:0] blkCount,
  input  logic             inValid,
  input  logic             outReady,
  output logic             busy,
  output logic             inTuple,
  output logic [2:0]       tupleIdx,
  output dpStrobeT         strb,
  output logic             done,
  output logic [7:0]       doneStatus,
  output logic             doneNoRetry
);

  localparam int POS_W = ((BLK_W > MD_W) ? BLK_W : MD_W) + 1;

  logic [BLK_W-1:0] blkReg;
  logic [MD_W-1:0]  mdReg;
  logic [1:0]       typeReg;
  logic             firstReg;
  logic [CNT_W-1:0] blkLeft;
  logic [POS_W-1:0] byteIdx;

  logic [POS_W-1:0] posEnd, mdOff, tupleBase;
  logic isMeta, crcCover, lastByte, lastBlk, beat, launch, reject;

  always_comb begin
    posEnd    = POS_W'(blkReg) + POS_W'(mdReg) - POS_W'(1);
    isMeta    = byteIdx >= POS_W'(blkReg);
    mdOff     = byteIdx - POS_W'(blkReg);
    tupleBase = firstReg ? '0 : (POS_W'(mdReg) - POS_W'(TUPLE_LEN));
    inTuple   = isMeta && (typeReg != 2'd0) && (mdOff >= tupleBase) &&
                (mdOff < tupleBase + POS_W'(TUPLE_LEN));
    tupleIdx  = 3'(mdOff - tupleBase);
    crcCover  = !isMeta || (mdOff < tupleBase);
    lastByte  = byteIdx == posEnd;
    lastBlk   = blkLeft == CNT_W'(1);
    beat      = busy && inValid && outReady;
    launch    = start && !busy;
    reject    = (piType == 2'd1) && refCheck && (startRef != lbaLow);
    strb.refLoad = launch;
    strb.crcClr  = launch || (beat && lastByte);
    strb.crcEn   = beat && crcCover;
    strb.refStep = beat && lastByte && (typeReg != 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      blkReg      <= '0;
      mdReg       <= '0;
      typeReg     <= '0;
      firstReg    <= 1'b0;
      blkLeft     <= '0;
      byteIdx     <= '0;
      done        <= 1'b0;
      doneStatus  <= STAT_OK;
      doneNoRetry <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        if (reject) begin
          done        <= 1'b1;
          doneStatus  <= STAT_BADPI;
          doneNoRetry <= 1'b1;
        end else begin
          busy     <= 1'b1;
          blkReg   <= blkBytes;
          mdReg    <= mdBytes;
          typeReg  <= piType;
          firstReg <= tupleFirst;
          blkLeft  <= blkCount;
          byteIdx  <= '0;
        end
      end else if (beat) begin
        if (lastByte) begin
          byteIdx <= '0;
          if (lastBlk) begin
            busy        <= 1'b0;
            done        <= 1'b1;
            doneStatus  <= STAT_OK;
            doneNoRetry <= 1'b0;
          end else begin
            blkLeft <= blkLeft - CNT_W'(1);
          end
        end else begin
          byteIdx <= byteIdx + POS_W'(1);
        end
      end
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a successful completion follows the end of a busy period
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    (done && !doneNoRetry) |-> (!busy && $past(busy)));

endmodule

// File: rtl/pi_gen_dp.sv
module pi_gen_dp
  import pi_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobeT    strb,
  input  logic [31:0] startRef,
  input  logic [15:0] appTag,
  input  logic [7:0]  inByte,
  input  logic        inTuple,
  input  logic [2:0]  tupleIdx,
  output logic [7:0]  outByte
);

  logic [15:0] guardReg;
  logic [15:0] appReg;
  logic [31:0] refReg;
  logic [7:0]  tupleByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardReg <= '0;
      appReg   <= '0;
      refReg   <= '0;
    end else begin
      if (strb.crcClr)      guardReg <= '0;
      else if (strb.crcEn)  guardReg <= crcByte(guardReg, inByte);
      if (strb.refLoad) begin
        refReg <= startRef;
        appReg <= appTag;
      end else if (strb.refStep) begin
        refReg <= refReg + 32'd1;
      end
    end
  end

  always_comb begin
    unique case (tupleIdx)
      3'd0: tupleByte = guardReg[15:8];
      3'd1: tupleByte = guardReg[7:0];
      3'd2: tupleByte = appReg[15:8];
      3'd3: tupleByte = appReg[7:0];
      3'd4: tupleByte = refReg[31:24];
      3'd5: tupleByte = refReg[23:16];
      3'd6: tupleByte = refReg[15:8];
      default: tupleByte = refReg[7:0];
    endcase
    outByte = inTuple ? tupleByte : inByte;
  end

  // R2: guard only moves when the control asks for it
  a_r2_guard_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.crcClr && !strb.crcEn) |=> $stable(guardReg));

  // R7: reference tag only moves on load or step
  a_r7_ref_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.refLoad && !strb.refStep) |=> $stable(refReg));

endmodule

// File: rtl/pi_tuple_gen.sv
module pi_tuple_gen
  import pi_gen_pkg::*;
#(
  parameter int BLK_W = 13,
  parameter int MD_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [BLK_W-1:0] blkBytes,
  input  logic [MD_W-1:0]  mdBytes,
  input  logic [1:0]       piType,
  input  logic             tupleFirst,
  input  logic             refCheck,
  input  logic [31:0]      startRef,
  input  logic [15:0]      appTag,
  input  logic [31:0]      lbaLow,
  input  logic [CNT_W-1:0] blkCount,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  output logic             inReady,
  output logic [7:0]       outByte,
  output logic             outValid,
  input  logic             outReady,
  output logic             busy,
  output logic             done,
  output logic [7:0]       doneStatus,
  output logic             doneNoRetry
);

  dpStrobeT   strb;
  logic       inTuple;
  logic [2:0] tupleIdx;

  pi_gen_ctrl #(.BLK_W(BLK_W), .MD_W(MD_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .blkBytes(blkBytes), .mdBytes(mdBytes),
    .piType(piType), .tupleFirst(tupleFirst), .refCheck(refCheck),
    .startRef(startRef), .lbaLow(lbaLow), .blkCount(blkCount),
    .inValid(inValid), .outReady(outReady), .busy(busy), .inTuple(inTuple),
    .tupleIdx(tupleIdx), .strb(strb), .done(done), .doneStatus(doneStatus),
    .doneNoRetry(doneNoRetry)
  );

  pi_gen_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .startRef(startRef), .appTag(appTag),
    .inByte(inByte), .inTuple(inTuple), .tupleIdx(tupleIdx), .outByte(outByte)
  );

  assign outValid = busy && inValid;
  assign inReady  = busy && outReady;

  // R1: nothing moves on either stream while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!outValid && !inReady));

  // R8: a no-retry completion always carries the refusal code
  a_r8_refuse_code: assert property (@(posedge clk) disable iff (!rstN)
    (done && doneNoRetry) |-> (doneStatus == STAT_BADPI));

  // R11: a stalled output never accepts input
  a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

endmodule

// File: tb/pi_tuple_gen_tb_top.sv
module pi_tuple_gen_tb_top;

  localparam int BLK_W = 13;
  localparam int MD_W  = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [BLK_W-1:0] blkBytes = '0;
  logic [MD_W-1:0]  mdBytes = '0;
  logic [1:0]  piType = '0;
  logic        tupleFirst = 1'b0, refCheck = 1'b0;
  logic [31:0] startRef = '0, lbaLow = '0;
  logic [15:0] appTag = '0;
  logic [CNT_W-1:0] blkCount = '0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0, outReady = 1'b1;
  logic        inReady, outValid, busy, done, doneNoRetry;
  logic [7:0]  outByte, doneStatus;

  always #4 clk = ~clk;  // 125 MHz

  pi_tuple_gen #(.BLK_W(BLK_W), .MD_W(MD_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .blkBytes(blkBytes), .mdBytes(mdBytes),
    .piType(piType), .tupleFirst(tupleFirst), .refCheck(refCheck),
    .startRef(startRef), .appTag(appTag), .lbaLow(lbaLow), .blkCount(blkCount),
    .inByte(inByte), .inValid(inValid), .inReady(inReady), .outByte(outByte),
    .outValid(outValid), .outReady(outReady), .busy(busy), .done(done),
    .doneStatus(doneStatus), .doneNoRetry(doneNoRetry)
  );

  typedef struct { logic [7:0] val; int req; } expT;
  expT expQ[$];
  int nChecks = 0;
  int nErrors = 0;

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL R%0d %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int crcStep(input int crc, input logic [7:0] b);
    int c;
    c = crc ^ (int'(b) << 8);
    for (int k = 0; k < 8; k++) begin
      if ((c & 32'h8000) != 0) c = ((c << 1) ^ 32'h8BB7) & 32'hFFFF;
      else c = (c << 1) & 32'hFFFF;
    end
    return c;
  endfunction

  function automatic logic [7:0] dByte(input bit ascii, input int b, input int i);
    if (ascii) return 8'(8'h31 + i);
    return 8'((b * 37 + i * 13 + 5) & 255);
  endfunction

  function automatic logic [7:0] mByte(input int b, input int i);
    return 8'((8'hA0 + b * 3 + i * 7) & 255);
  endfunction

  // scoreboard monitor: compare each output beat against the queue
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, 11, "unexpected output byte", int'(outByte), 0);
      end else begin
        expT e;
        e = expQ.pop_front();
        chk(outByte == e.val, e.req, "output byte", int'(outByte), int'(e.val));
      end
    end
  end

  task automatic push(input logic [7:0] v, input int req);
    expT e;
    e.val = v;
    e.req = req;
    expQ.push_back(e);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit stall);
    bit got;
    inValid = 1'b1;
    inByte  = v;
    if (stall) begin
      outReady = 1'b0;
      @(negedge clk);
      chk(inReady == 1'b0 && outValid == 1'b1, 11, "stall handshake",
          {inReady, outValid}, 2'b01);  // R11
      @(posedge clk); #1;
      outReady = 1'b1;
    end
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = inReady;
    end
    @(posedge clk); #1;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic runXfer(input int nBlk, input int blk, input int md, input int typ,
                         input bit first, input bit rchk, input logic [31:0] sref,
                         input logic [31:0] lba, input logic [15:0] app,
                         input bit ascii, input int knownGuard, input int dataTag,
                         input int guardTag, input int refTag, input bit stall);
    blkBytes = BLK_W'(blk); mdBytes = MD_W'(md); piType = 2'(typ);
    tupleFirst = first; refCheck = rchk; startRef = sref; lbaLow = lba;
    appTag = app; blkCount = CNT_W'(nBlk);
    pulseStart();
    for (int b = 0; b < nBlk; b++) begin
      int crc;
      int base;
      logic [31:0] rt;
      logic [15:0] g;
      base = first ? 0 : md - 8;
      rt = (typ == 3) ? sref : sref + 32'(b);
      crc = 0;
      for (int i = 0; i < blk; i++) crc = crcStep(crc, dByte(ascii, b, i));
      for (int i = 0; i < base; i++) crc = crcStep(crc, mByte(b, i));
      g = (knownGuard >= 0) ? 16'(knownGuard) : 16'(crc);
      for (int i = 0; i < blk; i++) push(dByte(ascii, b, i), dataTag);
      for (int i = 0; i < md; i++) begin
        if (typ != 0 && i >= base && i < base + 8) begin
          case (i - base)
            0: push(g[15:8], guardTag);
            1: push(g[7:0], guardTag);
            2: push(app[15:8], 5);   // R5
            3: push(app[7:0], 5);
            4: push(rt[31:24], refTag);
            5: push(rt[23:16], refTag);
            6: push(rt[15:8], refTag);
            default: push(rt[7:0], refTag);
          endcase
        end else begin
          push(mByte(b, i), (typ == 0) ? 9 : 4);  // R9 / R4 pass-through
        end
      end
      for (int i = 0; i < blk + md; i++) begin
        logic [7:0] v;
        int mo;
        mo = i - blk;
        if (i < blk) v = dByte(ascii, b, i);
        else if (typ != 0 && mo >= base && mo < base + 8) v = 8'h55;
        else v = mByte(b, mo);
        sendByte(v, stall && (i % 5 == 2));
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && doneStatus == 8'h00 && doneNoRetry == 1'b0, 10,
        "done after last byte", {done, doneStatus, doneNoRetry}, 10'b1_00000000_0);  // R10
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, 10, "done single cycle", {done, busy}, 0);
    chk(expQ.size() == 0, 11, "scoreboard drained", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, 10, "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(busy == 0 && outValid == 0 && inReady == 0 && done == 0, 1, "reset state",
        {busy, outValid, inReady, done}, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    chk(busy == 0 && outValid == 0 && inReady == 0, 1, "idle with input offered",
        {busy, outValid, inReady}, 0);
    inValid = 1'b0;

    // R2: known check value, tuple first
    runXfer(1, 9, 8, 1, 1'b1, 1'b1, 32'h0000_1234, 32'h0000_1234, 16'hBEEF,
            1'b1, 16'hD0DB, 2, 2, 6, 1'b0);
    // R3 R6 R11: tuple last, type 1, three blocks, stalls
    runXfer(3, 32, 16, 1, 1'b0, 1'b1, 32'h7FFF_FFFE, 32'h7FFF_FFFE, 16'h1357,
            1'b0, -1, 11, 3, 6, 1'b1);
    // R4 R7: tuple first with trailing metadata, type 3
    runXfer(2, 20, 16, 3, 1'b1, 1'b1, 32'hCAFE_0001, 32'h0000_0000, 16'h2468,
            1'b0, -1, 4, 4, 7, 1'b0);
    // R8 R6: type 2 ignores mismatch check
    runXfer(2, 12, 8, 2, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0099, 16'hA5A5,
            1'b0, -1, 8, 3, 6, 1'b0);
    // R9: type 0 passes all bytes
    runXfer(1, 10, 8, 0, 1'b0, 1'b0, 32'h1, 32'h1, 16'h0,
            1'b0, -1, 9, 9, 9, 1'b1);

    // R8: refused start
    blkBytes = BLK_W'(16); mdBytes = MD_W'(8); piType = 2'd1; tupleFirst = 1'b0;
    refCheck = 1'b1; startRef = 32'h5; lbaLow = 32'h6; blkCount = CNT_W'(1);
    inValid = 1'b1; inByte = 8'h11;
    pulseStart();
    @(negedge clk);
    chk(done == 1 && doneStatus == 8'h81 && doneNoRetry == 1, 8, "refusal completion",
        {done, doneStatus, doneNoRetry}, 10'b1_10000001_1);
    chk(busy == 0 && inReady == 0 && outValid == 0, 8, "refused start takes no byte",
        {busy, inReady, outValid}, 0);
    @(negedge clk);
    chk(done == 0 && inReady == 0, 8, "refusal pulse ends, still idle", {done, inReady}, 0);
    inValid = 1'b0;

    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule